// File: doc/BRIEF.md
# Indirect Codec Register Access Bridge

This bridge gives a bus host access to a small bank of 8-bit codec control registers through two 32-bit memory-mapped words instead of a direct address window. The host writes a command word that carries a write strobe, a 7-bit internal index and one data byte. A companion data word returns the contents of the selected internal register, together with the level of the codec interrupt line.

Internal writes are not instantaneous. Once a write command is accepted, the strobe bit reads back as set for a parameterised number of core cycles and then clears itself when the byte commits. A command with the strobe clear only selects an index. The selected register then appears in the data word after a fixed pipeline latency. Commands that arrive while a write is pending are dropped, and a sticky error flag records each one.

The bank has fixed reset defaults, a read-only status entry fed from the codec core, and two unimplemented indices. Indices at or beyond the bank size also behave as unimplemented.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset the command word (offset 0x0) reads 0x00000000. After RD_LAT cycles the data word (offset 0x4) shows index 0 in bits 7:0.
- R2: An accepted command with bit 16 set makes bit 16 of the command word read 1 for exactly WR_CYC cycles after the accepting edge. Bit 16 then reads 0 and the byte in bits 7:0 is stored at the index in bits 14:8.
- R3: A command word write that arrives while bit 16 reads 1 is ignored. Bit 17 of the command word then reads 1, and the target index keeps its old value.
- R4: Bit 17 stays 1 until a command word write with bit 17 set is accepted while idle. That write clears the bit and is still treated as a normal command.
- R5: A command with bit 16 clear selects an index without setting busy. The selected index's contents appear in bits 7:0 of the data word exactly RD_LAT cycles after the accepting edge; the old contents stay there until then. RD_LAT must not exceed 6.
- R6: Reset defaults: indices 1 and 2 reset to 0xC3, indices 3 and 4 to 0x90, index 6 to 0x80 and index 11 to 0x03. Every other writable index resets to 0x00.
- R7: Indices 5 and 28, and every index from N_REGS (36) upward, ignore writes and read 0x00. Index 35 is writable.
- R8: Index 0 reads the status_i input, and writes to index 0 have no effect.
- R9: Bit 8 of the data word equals irq_i as sampled at the previous clock edge.
- R10: The command word reads back bits 14:8 and 7:0 from the last accepted command, with all other unlisted bits 0. Bus writes to the data word offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Bus write when 1 |
| addr_i | input | BUS_AW | Byte offset (0x0 command, 0x4 data) |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data for the offset on addr_i |
| status_i | input | 8 | Live status byte shown at index 0 |
| irq_i | input | 1 | Codec interrupt level |

## Verification
The bench builds the bridge with WR_CYC = 5 and RD_LAT = 4, which differ from the defaults. This exercises the busy counter and the read pipeline with non-default depths. The longer write window leaves room to land a second command inside it, so rejection and the sticky flag can be observed. The four-stage read pipeline lets the bench see the previous index's byte one cycle before the newly selected one replaces it. The boundary indices 5, 28, 35 and 40 cover both holes, the last real entry and the unpopulated range.

// File: rtl/codec_bridge_pkg.sv
package codec_bridge_pkg;
  localparam int unsigned STB_BIT  = 16;
  localparam int unsigned ERR_BIT  = 17;
  localparam int unsigned IDX_LSB  = 8;
  localparam int unsigned IRQ_BIT  = 8;

  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      1, 2:    return 8'hC3;
      3, 4:    return 8'h90;
      6:       return 8'h80;
      11:      return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_hole(int unsigned idx);
    return (idx == 5) || (idx == 28);
  endfunction
endpackage

// File: rtl/cbr_cmd_ctrl.sv
module cbr_cmd_ctrl #(
  parameter int unsigned WR_CYC = 4,
  parameter int unsigned AW     = 7,
  parameter int unsigned DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic          stb_i,
  input  logic          clr_err_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          err_o,
  output logic [AW-1:0] idx_o,
  output logic [DW-1:0] data_o,
  output logic          commit_o
);
  localparam int unsigned CW = (WR_CYC > 1) ? $clog2(WR_CYC) : 1;

  logic          busy_q, err_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] idx_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_wr_i && busy_q)         err_q <= 1'b1;
      else if (cmd_wr_i && clr_err_i) err_q <= 1'b0;

      if (cmd_wr_i && !busy_q) begin
        idx_q  <= idx_i;
        data_q <= data_i;
        if (stb_i) begin
          busy_q <= 1'b1;
          cnt_q  <= CW'(WR_CYC - 1);
        end
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign err_o    = err_q;
  assign idx_o    = idx_q;
  assign data_o   = data_q;
  assign commit_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/cbr_reg_bank.sv
module cbr_reg_bank
  import codec_bridge_pkg::*;
#(
  parameter int unsigned N_REGS = 36,
  parameter int unsigned AW     = 7,
  parameter int unsigned DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_idx_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] vals [N_REGS];

  for (genvar i = 0; i < N_REGS; i++) begin : g_ent
    if (i == 0) begin : g_stat
      assign vals[i] = status_i;
    end else if (is_hole(i)) begin : g_hole
      assign vals[i] = '0;
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 q <= DW'(reg_default(i));
        else if (commit_i && (wr_idx_i == AW'(i)))   q <= wr_data_i;
      end
      assign vals[i] = q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < N_REGS; k++)
      if (rd_idx_i == AW'(k)) rd_data_o = vals[k];
  end
endmodule

// File: rtl/cbr_read_pipe.sv
module cbr_read_pipe #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] st [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[DEPTH-1];
endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
  import codec_bridge_pkg::*;
#(
  parameter int unsigned N_REGS = 36,
  parameter int unsigned AW     = 7,
  parameter int unsigned DW     = 8,
  parameter int unsigned WR_CYC = 4,
  parameter int unsigned RD_LAT = 3,
  parameter int unsigned BUS_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [DW-1:0]     status_i,
  input  logic              irq_i
);
  localparam int unsigned SW = BUS_AW - 2;

  logic [SW-1:0] word_sel;
  logic          cmd_wr, busy, err, commit, irq_q;
  logic [AW-1:0] idx;
  logic [DW-1:0] cdata, bank_rd, rd_pipe;
  logic          unused_bits;

  assign word_sel    = addr_i[BUS_AW-1:2];
  assign cmd_wr      = req_i && we_i && (word_sel == SW'(0));
  assign unused_bits = ^{addr_i[1:0], wdata_i[31:ERR_BIT+1], wdata_i[IDX_LSB+AW +: 1],
                         wdata_i[IDX_LSB-1:DW]} ^ (^wdata_i[STB_BIT-1:IDX_LSB+AW]);

  cbr_cmd_ctrl #(.WR_CYC(WR_CYC), .AW(AW), .DW(DW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_wr_i  (cmd_wr),
    .stb_i     (wdata_i[STB_BIT]),
    .clr_err_i (wdata_i[ERR_BIT]),
    .idx_i     (wdata_i[IDX_LSB +: AW]),
    .data_i    (wdata_i[DW-1:0]),
    .busy_o    (busy),
    .err_o     (err),
    .idx_o     (idx),
    .data_o    (cdata),
    .commit_o  (commit)
  );

  cbr_reg_bank #(.N_REGS(N_REGS), .AW(AW), .DW(DW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .wr_idx_i  (idx),
    .wr_data_i (cdata),
    .rd_idx_i  (idx),
    .status_i  (status_i),
    .rd_data_o (bank_rd)
  );

  cbr_read_pipe #(.DW(DW), .DEPTH(RD_LAT)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (bank_rd),
    .q_o    (rd_pipe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_i;
  end

  always_comb begin
    rdata_o = '0;
    if (word_sel == SW'(0)) begin
      rdata_o[ERR_BIT]           = err;
      rdata_o[STB_BIT]           = busy;
      rdata_o[IDX_LSB +: AW]     = idx;
      rdata_o[DW-1:0]            = cdata;
    end else if (word_sel == SW'(1)) begin
      rdata_o[IRQ_BIT]           = irq_q;
      rdata_o[DW-1:0]            = rd_pipe;
    end
  end
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int unsigned WR_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_wr_i,
  input logic stb_i,
  input logic clr_i,
  input logic busy_i,
  input logic err_i
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_i) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  a_r2_write_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && stb_i && !busy_i |=> busy_i);

  a_r2_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> run_q < WR_CYC);

  a_r2_busy_full_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> run_q == WR_CYC);

  a_r3_reject_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && busy_i |=> err_i);

  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i && !(cmd_wr_i && clr_i && !busy_i) |=> err_i);

  a_r4_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && clr_i && !busy_i |=> !err_i);

  a_r5_select_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && !stb_i && !busy_i |=> !busy_i);
endmodule

bind codec_reg_bridge cbr_checker #(.WR_CYC(WR_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cmd_wr_i (cmd_wr),
  .stb_i    (wdata_i[16]),
  .clr_i    (wdata_i[17]),
  .busy_i   (busy),
  .err_i    (err)
);

// File: tb/codec_reg_bridge_test.sv
module codec_reg_bridge_test;
  localparam int unsigned WR_CYC = 5;
  localparam int unsigned RD_LAT = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, irq_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  status_i = 8'h5A;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  codec_reg_bridge #(.WR_CYC(WR_CYC), .RD_LAT(RD_LAT)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .status_i(status_i), .irq_i(irq_i)
  );

  task automatic check(string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  function automatic logic [31:0] cmd(bit clr, bit stb, logic [6:0] idx, logic [7:0] d);
    return {14'b0, clr, stb, 1'b0, idx, d};
  endfunction

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wait_idle();
    logic [31:0] w;
    for (int i = 0; i < 64; i++) begin
      bus_rd(4'h0, w);
      if (!w[16]) break;
      @(negedge clk_i);
    end
  endtask

  task automatic reg_write(logic [6:0] idx, logic [7:0] d);
    bus_wr(4'h0, cmd(1'b0, 1'b1, idx, d));
    wait_idle();
  endtask

  task automatic reg_read(logic [6:0] idx, output logic [7:0] d);
    logic [31:0] w;
    bus_wr(4'h0, cmd(1'b0, 1'b0, idx, 8'h00));
    repeat (RD_LAT) @(negedge clk_i);
    bus_rd(4'h4, w);
    d = w[7:0];
  endtask

  task automatic t_reset();
    logic [31:0] w;
    bus_rd(4'h0, w);
    check("R1 cmd word after reset", w, 32'h0);
    repeat (RD_LAT) @(negedge clk_i);
    bus_rd(4'h4, w);
    check("R1 data word shows index 0", w, 32'h0000_005A);
  endtask

  task automatic t_defaults();
    logic [7:0] d;
    reg_read(7'd1, d);  check("R6 default idx1", {24'b0, d}, 32'hC3);
    reg_read(7'd2, d);  check("R6 default idx2", {24'b0, d}, 32'hC3);
    reg_read(7'd3, d);  check("R6 default idx3", {24'b0, d}, 32'h90);
    reg_read(7'd4, d);  check("R6 default idx4", {24'b0, d}, 32'h90);
    reg_read(7'd6, d);  check("R6 default idx6", {24'b0, d}, 32'h80);
    reg_read(7'd11, d); check("R6 default idx11", {24'b0, d}, 32'h03);
    reg_read(7'd10, d); check("R6 default idx10", {24'b0, d}, 32'h00);
  endtask

  task automatic t_write_busy();
    logic [31:0] w;
    logic [7:0]  d;
    bus_wr(4'h0, cmd(1'b0, 1'b1, 7'd9, 8'h77));
    for (int i = 0; i < WR_CYC; i++) begin
      bus_rd(4'h0, w);
      check("R2 busy during write", {31'b0, w[16]}, 32'd1);
      @(negedge clk_i);
    end
    bus_rd(4'h0, w);
    check("R2 busy clears after window", {31'b0, w[16]}, 32'd0);
    check("R10 cmd readback", w, cmd(1'b0, 1'b0, 7'd9, 8'h77));
    reg_read(7'd9, d);
    check("R2 write committed", {24'b0, d}, 32'h77);
  endtask

  task automatic t_latency();
    logic [31:0] w;
    bus_wr(4'h0, cmd(1'b0, 1'b0, 7'd4, 8'h00));
    bus_rd(4'h0, w);
    check("R5 select sets no busy", {31'b0, w[16]}, 32'd0);
    repeat (RD_LAT - 1) @(negedge clk_i);
    bus_rd(4'h4, w);
    check("R5 old data before latency", {24'b0, w[7:0]}, 32'h77);
    @(negedge clk_i);
    bus_rd(4'h4, w);
    check("R5 new data at latency", {24'b0, w[7:0]}, 32'h90);
  endtask

  task automatic t_reject();
    logic [31:0] w;
    logic [7:0]  d;
    bus_wr(4'h0, cmd(1'b0, 1'b1, 7'd7, 8'h11));
    bus_wr(4'h0, cmd(1'b0, 1'b1, 7'd8, 8'h22));
    bus_rd(4'h0, w);
    check("R3 err set, first cmd kept", w, cmd(1'b1, 1'b1, 7'd7, 8'h11));
    wait_idle();
    reg_read(7'd8, d); check("R3 rejected target untouched", {24'b0, d}, 32'h00);
    reg_read(7'd7, d); check("R3 first write landed", {24'b0, d}, 32'h11);
    bus_rd(4'h0, w);
    check("R4 err sticky after idle cmd", {31'b0, w[17]}, 32'd1);
    bus_wr(4'h0, cmd(1'b1, 1'b0, 7'd3, 8'h00));
    bus_rd(4'h0, w);
    check("R4 err cleared", w, cmd(1'b0, 1'b0, 7'd3, 8'h00));
  endtask

  task automatic t_holes();
    logic [7:0] d;
    reg_write(7'd5, 8'hAA);  reg_read(7'd5, d);
    check("R7 hole idx5", {24'b0, d}, 32'h00);
    reg_write(7'd28, 8'h55); reg_read(7'd28, d);
    check("R7 hole idx28", {24'b0, d}, 32'h00);
    reg_write(7'd40, 8'h12); reg_read(7'd40, d);
    check("R7 beyond bank idx40", {24'b0, d}, 32'h00);
    reg_write(7'd35, 8'hEE); reg_read(7'd35, d);
    check("R7 last real idx35", {24'b0, d}, 32'hEE);
  endtask

  task automatic t_status();
    logic [7:0] d;
    reg_write(7'd0, 8'hFF); reg_read(7'd0, d);
    check("R8 status write ignored", {24'b0, d}, 32'h5A);
    status_i = 8'h3C;
    repeat (RD_LAT) @(negedge clk_i);
    reg_read(7'd0, d);
    check("R8 status follows input", {24'b0, d}, 32'h3C);
  endtask

  task automatic t_irq();
    logic [31:0] w;
    @(negedge clk_i); irq_i = 1'b1;
    bus_rd(4'h4, w);
    check("R9 irq not yet sampled", {31'b0, w[8]}, 32'd0);
    @(negedge clk_i);
    bus_rd(4'h4, w);
    check("R9 irq level high", {31'b0, w[8]}, 32'd1);
    irq_i = 1'b0;
    @(negedge clk_i);
    bus_rd(4'h4, w);
    check("R9 irq level low", {31'b0, w[8]}, 32'd0);
  endtask

  task automatic t_data_word_write();
    logic [31:0] w;
    bus_wr(4'h4, cmd(1'b0, 1'b1, 7'd12, 8'h99));
    bus_rd(4'h0, w);
    check("R10 data-offset write ignored", w, cmd(1'b0, 1'b0, 7'd0, 8'h00));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_defaults();
    t_write_busy();
    t_latency();
    t_reject();
    t_holes();
    t_status();
    t_irq();
    t_data_word_write();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule